// File: doc/BRIEF.md
# Self-Clocked Serial Result Transmitter

This block is the output engine of a sampling converter that drives its own serial clock. The converter core gives it a start strobe, a done strobe and a 16-bit result. From these it produces the busy output, a gated serial clock, a frame signal that marks valid data, and the serial data line. The serial clock is derived from the system clock by a programmable clock-enable divider. Each data bit takes three equal phases: a setup phase with the clock low, a high phase, and a hold phase with the clock low again. The data line therefore never moves near either clock edge, and a host may sample on the rising or on the falling edge.

Two timing modes are offered. In read-after mode, the fresh result goes out as soon as the conversion finishes, and busy stays high until the last bit has been sent. In read-during mode, the result stored by the previous conversion goes out while the new conversion runs, and busy falls as soon as that conversion ends. The serial clock and the frame signal can each be inverted by a configuration input.

Top module: `result_serial_master`

## Requirements
- R1: A frame carries exactly 16 clock pulses and 16 data bits, most significant bit first, with one bit per pulse.
- R2: The frame signal is active for exactly the duration of a frame. Outside a frame the logical serial clock stays at its idle level, which is low.
- R3: The data line holds its value across every rising and every falling serial clock edge. It changes only while the clock is low, one phase after a falling edge.
- R4: Each phase lasts `cfg_div` system clock cycles, and a value of 0 acts as 1. A frame therefore lasts 48 × max(cfg_div,1) cycles, counted from the cycle after its trigger.
- R5: `cfg_inv_sclk` inverts the serial clock pin and `cfg_inv_sync` inverts the frame pin, including their idle levels.
- R6: Busy rises in the cycle after `conv_start` is sampled while the block is idle. A `conv_start` that arrives while busy is high is ignored.
- R7: In read-after mode (`cfg_read_during`=0 when `conv_start` is sampled), a frame carrying `conv_result` starts in the cycle after `conv_done`. Busy stays high through that frame and falls in the same cycle as the frame signal.
- R8: In read-during mode (`cfg_read_during`=1), a frame starts in the cycle after `conv_start` and carries the previously stored result, which is zero after reset. Busy falls in the cycle after `conv_done`.
- R9: The stored result is loaded only on `conv_done`. A frame already in progress keeps sending its own word, and the new word goes out in the next read-during frame.
- R10: After reset, busy is low, the frame signal is inactive, the serial clock is at its idle level, and data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | 8 | System cycles per serial phase (0 acts as 1) |
| cfg_read_during | input | 1 | 1: send the previous result during conversion; 0: send the new result after it |
| cfg_inv_sclk | input | 1 | Invert the serial clock pin |
| cfg_inv_sync | input | 1 | Invert the frame pin |
| conv_start | input | 1 | One-cycle strobe: a conversion begins |
| conv_done | input | 1 | One-cycle strobe: the conversion result is ready |
| conv_result | input | 16 | Conversion result, valid with conv_done |
| busy | output | 1 | Conversion (and, in read-after mode, transfer) in progress |
| ser_clk | output | 1 | Generated serial clock |
| ser_sync | output | 1 | Frame signal, active while serial data is valid |
| ser_data | output | 1 | Serial data, MSB first |

## Verification
On every cycle, the bound checker confirms four things: the clock is gated off outside a frame, the data stays put around both clock edges, a pulse counter reads sixteen when a frame closes, and busy covers the whole frame in read-after mode. It also confirms that busy drops right after the done strobe in read-during mode and that busy only rises after a start strobe. Other behaviours depend on a sequence of conversions, and only the directed scenarios can show them. These are: the exact word and bit order received, which word a read-during frame carries (zero after reset, then each stored result), a new result arriving in the middle of a frame without disturbing it, the frame length for several divider settings including zero, the inverted idle levels, and a start strobe being ignored while busy is high.

// File: rtl/rstx_pkg.sv
// Shared types for the serial result transmitter.
// Assumes: one package per block, imported by every submodule.
package rstx_pkg;
    // Conversion / transfer control state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_SEND = 2'd2
    } ctl_state_e;

    // Phases of one serial bit
    typedef enum logic [1:0] {
        PH_SETUP = 2'd0,
        PH_HIGH  = 2'd1,
        PH_HOLD  = 2'd2
    } bit_phase_e;

    localparam int unsigned PHASES_PER_BIT = 3;
endpackage

// File: rtl/rstx_phase_div.sv
// Clock-enable divider: while run is high it emits one tick every
// max(div_cfg,1) cycles. It restarts from zero whenever run is low.
// Assumes: div_cfg is stable while run is high.
module rstx_phase_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    // End of phase: the count reached div_cfg-1 (a setting of 0 counts as 1)
    assign at_end = (div_cfg == '0) ? 1'b1 : (cnt_q == div_cfg - 1'b1);
    assign tick   = run && at_end;

    // Phase counter, cleared when idle or at the end of a phase
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run || at_end)  cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rstx_shifter.sv
// Frame sequencer: on load it captures a word and sends it MSB first.
// Each bit takes three ticks: setup (clock low), high, hold (clock low).
// Assumes: load is not asserted while a frame is active.
module rstx_shifter
    import rstx_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              tick,
    output logic              active,
    output logic              sclk,
    output logic              data,
    output logic              done
);
    localparam int unsigned CNT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] sreg_q;
    logic [CNT_W-1:0]  bit_q;
    bit_phase_e        ph_q;
    logic              last_bit;

    assign last_bit = (bit_q == CNT_W'(WORD_W - 1));
    assign done     = active && tick && (ph_q == PH_HOLD) && last_bit;
    assign sclk     = active && (ph_q == PH_HIGH);
    assign data     = active && sreg_q[WORD_W-1];

    // Load the word, then step through phases and bits on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sreg_q <= '0;
            bit_q  <= '0;
            ph_q   <= PH_SETUP;
        end else if (load) begin
            active <= 1'b1;
            sreg_q <= load_word;
            bit_q  <= '0;
            ph_q   <= PH_SETUP;
        end else if (active && tick) begin
            case (ph_q)
                PH_SETUP: ph_q <= PH_HIGH;
                PH_HIGH:  ph_q <= PH_HOLD;
                default: begin
                    if (last_bit) begin
                        active <= 1'b0;
                    end else begin
                        ph_q   <= PH_SETUP;
                        bit_q  <= bit_q + 1'b1;
                        sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rstx_busy_ctrl.sv
// Conversion control: owns busy and the stored result, and decides when
// a frame starts and which word it carries, according to the mode.
// Assumes: strobes are one cycle wide; the mode changes only while no
// frame is active.
module rstx_busy_ctrl
    import rstx_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] conv_word,
    input  logic              mode_during,
    input  logic              xfer_active,
    input  logic              xfer_done,
    output logic              busy,
    output logic              mode_q,
    output logic              load,
    output logic [WORD_W-1:0] load_word
);
    ctl_state_e        st_q;
    logic [WORD_W-1:0] result_q;

    assign busy = (st_q != ST_IDLE);

    // Frame trigger and word select for both modes
    always_comb begin
        load      = 1'b0;
        load_word = result_q;
        if (st_q == ST_IDLE && conv_start && mode_during && !xfer_active) begin
            load = 1'b1;
        end else if (st_q == ST_CONV && conv_done && !mode_q) begin
            load      = 1'b1;
            load_word = conv_word;
        end
    end

    // State, latched mode and stored result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            mode_q   <= 1'b0;
            result_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (conv_start) begin
                    st_q   <= ST_CONV;
                    mode_q <= mode_during;
                end
                ST_CONV: if (conv_done) begin
                    result_q <= conv_word;
                    st_q     <= mode_q ? ST_IDLE : ST_SEND;
                end
                default: if (xfer_done) st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/result_serial_master.sv
// Top of the self-clocked serial result transmitter: busy control,
// phase divider and frame sequencer, plus output polarity selection.
// Assumes: configuration inputs change only while busy is low and no
// frame is active.
module result_serial_master #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_read_during,
    input  logic              cfg_inv_sclk,
    input  logic              cfg_inv_sync,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] conv_result,
    output logic              busy,
    output logic              ser_clk,
    output logic              ser_sync,
    output logic              ser_data
);
    logic              xfer_active;
    logic              xfer_done;
    logic              tick;
    logic              sclk_raw;
    logic              data_raw;
    logic              mode_q;
    logic              load;
    logic [WORD_W-1:0] load_word;

    rstx_busy_ctrl #(.WORD_W(WORD_W)) ctl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_start  (conv_start),
        .conv_done   (conv_done),
        .conv_word   (conv_result),
        .mode_during (cfg_read_during),
        .xfer_active (xfer_active),
        .xfer_done   (xfer_done),
        .busy        (busy),
        .mode_q      (mode_q),
        .load        (load),
        .load_word   (load_word)
    );

    rstx_phase_div #(.DIV_W(DIV_W)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (xfer_active),
        .div_cfg (cfg_div),
        .tick    (tick)
    );

    rstx_shifter #(.WORD_W(WORD_W)) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .tick      (tick),
        .active    (xfer_active),
        .sclk      (sclk_raw),
        .data      (data_raw),
        .done      (xfer_done)
    );

    // Output polarity selection
    assign ser_clk  = sclk_raw ^ cfg_inv_sclk;
    assign ser_sync = xfer_active ^ cfg_inv_sync;
    assign ser_data = data_raw;
endmodule

// File: rtl/result_serial_master_chk.sv
// Property checker for result_serial_master, attached with bind.
// Assumes: it sees the logical (uninverted) clock and frame signals.
module result_serial_master_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic sclk_raw,
    input logic sync_raw,
    input logic data_raw,
    input logic busy,
    input logic mode_q,
    input logic conv_start,
    input logic conv_done
);
    localparam int unsigned PC_W = $clog2(WORD_W) + 2;

    logic [PC_W-1:0] pulses_q;
    logic            sclk_d;

    // Count clock rising edges inside the current frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses_q <= '0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d   <= sclk_raw;
            pulses_q <= !sync_raw ? '0 : pulses_q + PC_W'(sclk_raw && !sclk_d);
        end
    end

    p_pulse_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_raw) |-> pulses_q == PC_W'(WORD_W));

    p_clk_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_raw |-> !sclk_raw);

    p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_raw) || $fell(sclk_raw)) |-> $stable(data_raw));

    p_busy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(conv_start));

    p_busy_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && sync_raw) |-> busy);

    p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && busy && conv_done) |=> !busy);
endmodule

bind result_serial_master result_serial_master_chk #(.WORD_W(WORD_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_raw   (sclk_raw),
    .sync_raw   (xfer_active),
    .data_raw   (data_raw),
    .busy       (busy),
    .mode_q     (mode_q),
    .conv_start (conv_start),
    .conv_done  (conv_done)
);

// File: tb/result_serial_master_tb_top.sv
// Directed bench for result_serial_master: one task per scenario.
module result_serial_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_div = 8'd1;
    logic        cfg_read_during = 1'b0;
    logic        cfg_inv_sclk = 1'b0;
    logic        cfg_inv_sync = 1'b0;
    logic        conv_start = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_result = '0;
    logic        busy, ser_clk, ser_sync, ser_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    result_serial_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
        .cfg_read_during(cfg_read_during), .cfg_inv_sclk(cfg_inv_sclk),
        .cfg_inv_sync(cfg_inv_sync), .conv_start(conv_start),
        .conv_done(conv_done), .conv_result(conv_result),
        .busy(busy), .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_data(ser_data)
    );

    // Port monitor, sampled on the falling edge
    logic        sck_d = 0, syn_d = 0, busy_d = 0, rise_bit = 0;
    logic [15:0] cur_word = 0, last_word = 0;
    int cur_pulses = 0, last_pulses = 0, cur_len = 0, last_len = 0;
    int frames = 0, cyc = 0, sync_fall_cyc = -1, busy_fall_cyc = -2;
    int edge_bad = 0, idle_bad = 0;
    always @(negedge clk) begin
        logic sck, syn;
        sck = ser_clk ^ cfg_inv_sclk;
        syn = ser_sync ^ cfg_inv_sync;
        cyc++;
        if (rst_n) begin
            if (syn && !syn_d) begin cur_word = 0; cur_pulses = 0; cur_len = 0; end
            if (syn) cur_len++;
            if (syn && sck && !sck_d) begin
                cur_word = {cur_word[14:0], ser_data}; cur_pulses++; rise_bit = ser_data;
            end
            if (syn && !sck && sck_d && ser_data != rise_bit) edge_bad++;
            if (!syn && sck) idle_bad++;
            if (!syn && syn_d) begin
                frames++; last_word = cur_word; last_pulses = cur_pulses;
                last_len = cur_len; sync_fall_cyc = cyc;
            end
            if (!busy && busy_d) busy_fall_cyc = cyc;
        end
        sck_d = sck; syn_d = syn; busy_d = busy;
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
    endtask

    task automatic pulse_done(input logic [15:0] w);
        conv_result = w; conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        int n = 0;
        while (frames < target && n < 5000) begin @(posedge clk); n++; end
        @(negedge clk);
        check("R1", "frame completion", frames, target);
    endtask

    task automatic frame_checks(input logic [15:0] w, input int div);
        int d;
        d = (div == 0) ? 1 : div;
        check("R1", "received word", last_word, w);
        check("R1", "pulse count", last_pulses, 16);
        check("R3", "data moved at clock edge", edge_bad, 0);
        check("R2", "clock active outside frame", idle_bad, 0);
        check("R4", "frame length", last_len, 48 * d);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "busy after reset", busy, 0);
        check("R10", "sync after reset", ser_sync, 0);
        check("R10", "sclk after reset", ser_clk, 0);
        check("R10", "data after reset", ser_data, 0);
    endtask

    task automatic t_during(input logic [15:0] prev, input logic [15:0] nxt, input int div);
        int f;
        f = frames;
        cfg_read_during = 1'b1; cfg_div = 8'(div); #1;
        pulse_start();
        check("R8", "busy at start", busy, 1);
        check("R8", "frame opens with start", ser_sync ^ cfg_inv_sync, 1);
        wait_frames(f + 1);
        frame_checks(prev, div);
        check("R8", "busy held until done", busy, 1);
        pulse_done(nxt);
        check("R8", "busy drops after done", busy, 0);
    endtask

    task automatic t_after(input logic [15:0] w, input int div, input logic ic, input logic is);
        int f;
        f = frames;
        cfg_read_during = 1'b0; cfg_div = 8'(div);
        cfg_inv_sclk = ic; cfg_inv_sync = is; #1;
        check("R5", "idle sclk pin level", ser_clk, int'(ic));
        check("R5", "idle sync pin level", ser_sync, int'(is));
        pulse_start();
        check("R6", "busy rises after start", busy, 1);
        repeat (5) @(negedge clk);
        check("R7", "no frame before done", ser_sync ^ is, 0);
        pulse_done(w);
        check("R7", "frame opens after done", ser_sync ^ is, 1);
        check("R7", "busy held after done", busy, 1);
        wait_frames(f + 1);
        frame_checks(w, div);
        check("R7", "busy falls with sync", busy_fall_cyc, sync_fall_cyc);
        check("R7", "busy low after frame", busy, 0);
    endtask

    task automatic t_overlap(input logic [15:0] prev, input logic [15:0] nw);
        int f;
        f = frames;
        cfg_read_during = 1'b1; cfg_div = 8'd4; cfg_inv_sclk = 0; cfg_inv_sync = 0; #1;
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_done(nw);
        check("R9", "busy drops mid-frame", busy, 0);
        check("R9", "frame continues", ser_sync, 1);
        wait_frames(f + 1);
        check("R9", "frame word unaffected", last_word, prev);
        pulse_start();
        wait_frames(f + 2);
        check("R9", "stored word sent next", last_word, nw);
        pulse_done(16'h0);
    endtask

    task automatic t_ignore(input logic [15:0] w);
        int f;
        f = frames;
        cfg_read_during = 1'b0; cfg_div = 8'd2; #1;
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_done(w);
        repeat (30) @(negedge clk);
        pulse_start();
        wait_frames(f + 1);
        check("R6", "word with ignored start", last_word, w);
        repeat (200) @(negedge clk);
        check("R6", "busy stays low", busy, 0);
        check("R6", "no extra frame", frames, f + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_during(16'h0000, 16'h5AF0, 1);
        t_during(16'h5AF0, 16'h0F0F, 2);
        t_after(16'hA5C3, 1, 1'b0, 1'b0);
        t_after(16'h8001, 3, 1'b1, 1'b1);
        t_after(16'h7FFE, 0, 1'b0, 1'b1);
        t_overlap(16'h7FFE, 16'h1234);
        t_ignore(16'hC3A5);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule